// File: doc/BRIEF.md
# Beacon Target Timer Unit

This block keeps the local 64-bit time synchronisation counter of a wireless MAC and four 16-bit beacon schedule timers driven from it. The counter advances by one on every microsecond tick strobe. One time unit (TU) is 2^TU_SHIFT counter microseconds. The four timers are: next beacon target, DMA beacon alert, software beacon alert and ATIM window end. Each one holds a compare value. When the counter, reduced to that timer's resolution, equals the value, the timer emits a one-cycle event and moves forward by one beacon interval.

Software controls the unit through a small word-wide register port. Through it, software sets the counter halves, the timers, the beacon interval, the timer enable and a counter-reset request. A separate load input lets the receive path force the counter to a new value, as happens when a beacon from the same network is adopted. The two 32-bit halves of the counter can be read coherently: a read of the lower half freezes the upper half for the next upper-half read.

The timers advance only on exact equality. A counter jump that lands past a timer value leaves that timer behind until the 16-bit compare count wraps around and reaches it again.

Top module: `beacon_timer_unit`

## Requirements
- R1: After a synchronous active-low reset, the counter, all four timers, the interval, the enable and the reset request read as zero, and no event output is high.
- R2: The counter increments by exactly one on each clock edge where `us_tick` is high, and holds its value otherwise. A register write to address 0 replaces bits [31:0] and a write to address 1 replaces bits [63:32].
- R3: A cycle with `tsf_load` high sets the counter to `tsf_load_val`. This takes precedence over register half-writes and ticks.
- R4: A read of address 0 returns counter bits [31:0] and, in the same cycle, captures bits [63:32] in a shadow. A read of address 1 returns that shadow, so the pair stays consistent even if the counter carries into the upper half between the two reads.
- R5: Each control write with bit 17 set toggles the counter-reset request, which reads back in control bit 17. The write that raises the request clears the counter to zero. The write that lowers it leaves the counter running.
- R6: While enabled, the next-beacon timer (address 2) and the ATIM-end timer (address 5) compare against TU count = counter bits [TU_SHIFT+15:TU_SHIFT]. On equality the timer emits a single-cycle event on the clock after the match and adds the interval (control bits [15:0]) to its value.
- R7: The DMA alert timer (address 3) and the software alert timer (address 4) hold eighths of a TU. They compare against counter bits [TU_SHIFT+12:TU_SHIFT-3] and advance by eight times the interval on a match.
- R8: With the enable (control bit 16) clear, no timer emits an event and no timer value changes except through writes.
- R9: A timer that the counter skips over because of a load is not advanced. It fires again only when the 16-bit compare count wraps and reaches its value exactly.
- R10: Writing the next-beacon timer also sets the ATIM-end timer to that value plus one. An ATIM-end write equal to the current next-beacon value is stored as that value plus one, so the window is never zero-length.
- R11: Register addresses are 0 counter low, 1 counter high, 2 next beacon, 3 DMA alert, 4 software alert, 5 ATIM end, 6 control. Timers read back zero-extended. Read data is valid on the clock after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_tick | input | 1 | One-cycle strobe per counter microsecond |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data, valid the cycle after `rd_en` |
| tsf_load | input | 1 | Force counter to `tsf_load_val` |
| tsf_load_val | input | 64 | Counter value adopted from a received beacon |
| evt_nbt | output | 1 | Next-beacon-target event pulse |
| evt_dma | output | 1 | DMA beacon alert event pulse |
| evt_swba | output | 1 | Software beacon alert event pulse |
| evt_atim | output | 1 | ATIM window end event pulse |

## Verification
The bench builds the unit with TU_SHIFT=4, so one TU lasts sixteen ticks. It holds the tick high in most tests, which puts three full beacon intervals of every timer, including the eighth-TU alert timers, within a few hundred cycles. TMR_W and ALERT_FRAC keep their defaults, so the compare width and the wrap behaviour are the real 16-bit ones. The wrap of the TU count, which would otherwise take over a million ticks, is reached by loading the counter to just below a wrapped image of a stranded timer.

// File: rtl/btu_pkg.sv
// Package: shared constants for the beacon target timer unit.
// Assumes a 64-bit counter accessed as two 32-bit halves.
package btu_pkg;
    localparam int TSF_W   = 64;
    localparam int HALF_W  = 32;
    localparam int ADDR_W  = 3;
    localparam int NUM_TMR = 4;

    localparam logic [ADDR_W-1:0] A_TSF_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_TSF_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_NBT    = 3'd2;
    localparam logic [ADDR_W-1:0] A_DMA    = 3'd3;
    localparam logic [ADDR_W-1:0] A_SWBA   = 3'd4;
    localparam logic [ADDR_W-1:0] A_ATIM   = 3'd5;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd6;

    // Timer slot indices; slot g lives at address A_NBT + g
    localparam int T_NBT  = 0;
    localparam int T_DMA  = 1;
    localparam int T_SWBA = 2;
    localparam int T_ATIM = 3;

    localparam int CTRL_EN_BIT  = 16;
    localparam int CTRL_RST_BIT = 17;

    // True for the slots that count in eighths of a time unit
    function automatic bit is_alert(int idx);
        return (idx == T_DMA) || (idx == T_SWBA);
    endfunction
endpackage

// File: rtl/btu_tsf_counter.sv
// Module: 64-bit time synchronisation counter.
// Priority: clear > external load > half-word write > tick increment.
// Assumes at most one of the write strobes per cycle.
module btu_tsf_counter
    import btu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              clr,
    input  logic              load,
    input  logic [TSF_W-1:0]  load_val,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [HALF_W-1:0] wr_val,
    output logic [TSF_W-1:0]  tsf
);
    // Counter state update in priority order
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tsf <= '0;
        end else if (clr) begin
            tsf <= '0;
        end else if (load) begin
            tsf <= load_val;
        end else if (wr_lo) begin
            tsf[HALF_W-1:0] <= wr_val;
        end else if (wr_hi) begin
            tsf[TSF_W-1:HALF_W] <= wr_val;
        end else if (tick) begin
            tsf <= tsf + 1'b1;
        end
    end
endmodule

// File: rtl/btu_timer_slot.sv
// Module: one beacon schedule timer.
// Fires a registered one-cycle event when enabled and the compare count
// equals the stored value, then advances by (interval << ADV_SHIFT).
// A load from the register port wins over the advance in the same cycle.
module btu_timer_slot #(
    parameter int TMR_W     = 16,
    parameter int ADV_SHIFT = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [TMR_W-1:0] cnt,
    input  logic [TMR_W-1:0] ival,
    input  logic             ld,
    input  logic [TMR_W-1:0] ld_val,
    output logic [TMR_W-1:0] tmr,
    output logic             evt
);
    logic [TMR_W-1:0] step;
    logic             match;

    // Interval scaled to this slot's resolution, wrapping at TMR_W bits
    assign step  = ival << ADV_SHIFT;
    // Exact-equality compare only; a skipped value is not caught up
    assign match = enable && (cnt == tmr);

    // Timer value and event pulse register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr <= '0;
            evt <= 1'b0;
        end else begin
            evt <= match;
            if (ld) begin
                tmr <= ld_val;
            end else if (match) begin
                tmr <= tmr + step;
            end
        end
    end
endmodule

// File: rtl/btu_read_port.sv
// Module: registered read mux with upper-half shadow.
// A low-half read captures the upper half; a high-half read returns it.
// Assumes TMR_W <= 32.
module btu_read_port
    import btu_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            rd_en,
    input  logic [ADDR_W-1:0]               rd_addr,
    input  logic [TSF_W-1:0]                tsf,
    input  logic [NUM_TMR-1:0][TMR_W-1:0]   tmr,
    input  logic [HALF_W-1:0]               ctrl_word,
    output logic [HALF_W-1:0]               rd_data
);
    logic [HALF_W-1:0] hi_shadow;

    // Read data and shadow capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data   <= '0;
            hi_shadow <= '0;
        end else if (rd_en) begin
            case (rd_addr)
                A_TSF_LO: begin
                    rd_data   <= tsf[HALF_W-1:0];
                    hi_shadow <= tsf[TSF_W-1:HALF_W];
                end
                A_TSF_HI: rd_data <= hi_shadow;
                A_NBT:    rd_data <= HALF_W'(tmr[T_NBT]);
                A_DMA:    rd_data <= HALF_W'(tmr[T_DMA]);
                A_SWBA:   rd_data <= HALF_W'(tmr[T_SWBA]);
                A_ATIM:   rd_data <= HALF_W'(tmr[T_ATIM]);
                A_CTRL:   rd_data <= ctrl_word;
                default:  rd_data <= '0;
            endcase
        end
    end
endmodule

// File: rtl/beacon_timer_unit.sv
// Module: beacon target timer unit top.
// Holds the counter, control state and four timer slots. The TU count is
// counter bits [TU_SHIFT +: TMR_W]; the eighth-TU count starts
// ALERT_FRAC bits lower. Assumes TU_SHIFT >= ALERT_FRAC and TMR_W <= 16.
module beacon_timer_unit
    import btu_pkg::*;
#(
    parameter int TMR_W      = 16,
    parameter int TU_SHIFT   = 10,
    parameter int ALERT_FRAC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              rd_en,
    input  logic [2:0]        rd_addr,
    output logic [31:0]       rd_data,
    input  logic              tsf_load,
    input  logic [63:0]       tsf_load_val,
    output logic              evt_nbt,
    output logic              evt_dma,
    output logic              evt_swba,
    output logic              evt_atim
);
    localparam int TU_LSB = TU_SHIFT;
    localparam int FR_LSB = TU_SHIFT - ALERT_FRAC;

    logic [TSF_W-1:0]              tsf_q;
    logic [TMR_W-1:0]              ival_q;
    logic                          en_q;
    logic                          rst_req_q;
    logic                          ctrl_wr;
    logic                          tsf_clr;
    logic [TMR_W-1:0]              tu_cnt;
    logic [TMR_W-1:0]              fr_cnt;
    logic [NUM_TMR-1:0]            ld;
    logic [NUM_TMR-1:0][TMR_W-1:0] ld_val;
    logic [NUM_TMR-1:0][TMR_W-1:0] tmr_q;
    logic [NUM_TMR-1:0]            evt_vec;
    logic [HALF_W-1:0]             ctrl_word;

    assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
    // Only the write that raises the request clears the counter
    assign tsf_clr = ctrl_wr && wr_data[CTRL_RST_BIT] && !rst_req_q;
    assign tu_cnt  = tsf_q[TU_LSB +: TMR_W];
    assign fr_cnt  = tsf_q[FR_LSB +: TMR_W];

    // Control register: interval, enable, toggling reset request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ival_q    <= '0;
            en_q      <= 1'b0;
            rst_req_q <= 1'b0;
        end else if (ctrl_wr) begin
            ival_q    <= wr_data[TMR_W-1:0];
            en_q      <= wr_data[CTRL_EN_BIT];
            rst_req_q <= rst_req_q ^ wr_data[CTRL_RST_BIT];
        end
    end

    // Control readback word
    always_comb begin
        ctrl_word               = '0;
        ctrl_word[TMR_W-1:0]    = ival_q;
        ctrl_word[CTRL_EN_BIT]  = en_q;
        ctrl_word[CTRL_RST_BIT] = rst_req_q;
    end

    // Timer load decode, including the non-zero ATIM window rule
    always_comb begin
        for (int g = 0; g < NUM_TMR; g++) begin
            ld[g]     = wr_en && (wr_addr == ADDR_W'(int'(A_NBT) + g));
            ld_val[g] = wr_data[TMR_W-1:0];
        end
        if (ld[T_NBT]) begin
            ld[T_ATIM]     = 1'b1;
            ld_val[T_ATIM] = wr_data[TMR_W-1:0] + 1'b1;
        end else if (ld[T_ATIM] && (wr_data[TMR_W-1:0] == tmr_q[T_NBT])) begin
            ld_val[T_ATIM] = tmr_q[T_NBT] + 1'b1;
        end
    end

    btu_tsf_counter u_tsf (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (us_tick),
        .clr      (tsf_clr),
        .load     (tsf_load),
        .load_val (tsf_load_val),
        .wr_lo    (wr_en && (wr_addr == A_TSF_LO)),
        .wr_hi    (wr_en && (wr_addr == A_TSF_HI)),
        .wr_val   (wr_data),
        .tsf      (tsf_q)
    );

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_slot
        localparam bit ALERT = is_alert(g);
        btu_timer_slot #(
            .TMR_W     (TMR_W),
            .ADV_SHIFT (ALERT ? ALERT_FRAC : 0)
        ) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .enable (en_q),
            .cnt    (ALERT ? fr_cnt : tu_cnt),
            .ival   (ival_q),
            .ld     (ld[g]),
            .ld_val (ld_val[g]),
            .tmr    (tmr_q[g]),
            .evt    (evt_vec[g])
        );
    end

    btu_read_port #(.TMR_W(TMR_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .tsf       (tsf_q),
        .tmr       (tmr_q),
        .ctrl_word (ctrl_word),
        .rd_data   (rd_data)
    );

    assign evt_nbt  = evt_vec[T_NBT];
    assign evt_dma  = evt_vec[T_DMA];
    assign evt_swba = evt_vec[T_SWBA];
    assign evt_atim = evt_vec[T_ATIM];
endmodule

// File: rtl/btu_checker.sv
// Module: temporal checks for beacon_timer_unit, attached by bind.
// Every property skips the first cycle after reset via $past(rst_n).
module btu_checker
    import btu_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          us_tick,
    input logic                          wr_en,
    input logic [ADDR_W-1:0]             wr_addr,
    input logic [31:0]                   wr_data,
    input logic                          tsf_load,
    input logic [TSF_W-1:0]              tsf_load_val,
    input logic [TSF_W-1:0]              tsf_q,
    input logic [NUM_TMR-1:0][TMR_W-1:0] tmr_q,
    input logic [NUM_TMR-1:0]            evt_vec,
    input logic [TMR_W-1:0]              ival_q,
    input logic                          en_q,
    input logic                          rst_req_q
);
    assert_tsf_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(us_tick) && !$past(wr_en) && !$past(tsf_load))
        |-> (tsf_q == $past(tsf_q) + 1'b1));

    assert_tsf_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(us_tick) && !$past(wr_en) && !$past(tsf_load))
        |-> (tsf_q == $past(tsf_q)));

    assert_tsf_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(tsf_load) && !$past(wr_en))
        |-> (tsf_q == $past(tsf_load_val)));

    assert_rst_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en && (wr_addr == A_CTRL)
                               && wr_data[CTRL_RST_BIT] && !rst_req_q))
        |-> (tsf_q == '0 && rst_req_q));

    assert_nbt_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && evt_vec[T_NBT] && !$past(wr_en && (wr_addr == A_NBT)))
        |-> (tmr_q[T_NBT] == TMR_W'($past(tmr_q[T_NBT]) + $past(ival_q))));

    assert_no_evt_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(en_q)) |-> (evt_vec == '0));

    assert_atim_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en && (wr_addr == A_NBT)))
        |-> (tmr_q[T_ATIM] == TMR_W'($past(wr_data[TMR_W-1:0]) + 1'b1)));
endmodule

bind beacon_timer_unit btu_checker #(.TMR_W(TMR_W)) u_btu_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .us_tick      (us_tick),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .tsf_load     (tsf_load),
    .tsf_load_val (tsf_load_val),
    .tsf_q        (tsf_q),
    .tmr_q        (tmr_q),
    .evt_vec      (evt_vec),
    .ival_q       (ival_q),
    .en_q         (en_q),
    .rst_req_q    (rst_req_q)
);

// File: tb/test_beacon_timer_unit.sv
// Directed bench for beacon_timer_unit, built with TU_SHIFT=4.
module test_beacon_timer_unit;
    localparam int CLK_PERIOD = 10;
    localparam int TU_SH      = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        us_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        tsf_load = 1'b0;
    logic [63:0] tsf_load_val = '0;
    logic        evt_nbt, evt_dma, evt_swba, evt_atim;

    int n_chk  = 0;
    int n_fail = 0;
    int n_evt[4] = '{0, 0, 0, 0};
    int base[4];
    int any_evt = 0;
    bit done = 1'b0;

    beacon_timer_unit #(.TU_SHIFT(TU_SH)) i_beacon_timer_unit (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .tsf_load(tsf_load), .tsf_load_val(tsf_load_val),
        .evt_nbt(evt_nbt), .evt_dma(evt_dma), .evt_swba(evt_swba), .evt_atim(evt_atim)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Event counters sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            n_evt[0] += int'(evt_nbt);
            n_evt[1] += int'(evt_dma);
            n_evt[2] += int'(evt_swba);
            n_evt[3] += int'(evt_atim);
            if (evt_nbt || evt_dma || evt_swba || evt_atim) any_evt++;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_range(input string req, input logic [63:0] act,
                             input logic [63:0] lo, input logic [63:0] hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h..%0h", req, act, lo, hi);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic ext_load(input logic [63:0] v);
        @(negedge clk);
        tsf_load = 1'b1; tsf_load_val = v;
        @(negedge clk);
        tsf_load = 1'b0;
    endtask

    task automatic snap();
        for (int i = 0; i < 4; i++) base[i] = n_evt[i];
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R1, R11: reset state of every register and the event outputs
    task automatic t_reset();
        logic [31:0] d;
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), d);
            chk($sformatf("R1 R11 reset addr %0d", a), 64'(d), 64'd0);
        end
        chk("R1 no events after reset", 64'(any_evt), 64'd0);
    endtask

    // R2, R3, R4: counting, half writes, external load, coherent reads
    task automatic t_counter();
        logic [31:0] d;
        ext_load(64'h1_FFFF_FFFF);
        rd(3'd0, d); chk("R3 load low half", 64'(d), 64'hFFFF_FFFF);
        rd(3'd1, d); chk("R3 load high half", 64'(d), 64'h1);
        @(negedge clk); us_tick = 1'b1;
        @(negedge clk); us_tick = 1'b0;
        rd(3'd0, d); chk("R2 one tick carries low", 64'(d), 64'h0);
        rd(3'd1, d); chk("R2 one tick carries high", 64'(d), 64'h2);
        wr(3'd0, 32'h1234);
        wr(3'd1, 32'h77);
        rd(3'd0, d); chk("R2 write low half", 64'(d), 64'h1234);
        rd(3'd1, d); chk("R2 write high half", 64'(d), 64'h77);
        idle(5);
        rd(3'd0, d); chk("R2 hold without tick", 64'(d), 64'h1234);
        us_tick = 1'b1;
        ext_load(64'h5_FFFF_FFF0);
        rd(3'd0, d); chk_range("R4 low read near carry", 64'(d), 64'hFFFF_FFF0, 64'hFFFF_FFF8);
        idle(30);
        rd(3'd1, d); chk("R4 shadow keeps upper half", 64'(d), 64'h5);
        rd(3'd0, d); chk_range("R4 low after carry", 64'(d), 64'h0, 64'h40);
        rd(3'd1, d); chk("R4 upper after carry", 64'(d), 64'h6);
    endtask

    // R5: toggling reset request
    task automatic t_rst_req();
        logic [31:0] d;
        ext_load(64'h3_0000_0000);
        wr(3'd6, 32'h0002_0000);
        rd(3'd6, d); chk("R5 request raised", 64'(d), 64'h2_0000);
        rd(3'd0, d); chk_range("R5 counter cleared low", 64'(d), 64'h0, 64'h10);
        rd(3'd1, d); chk("R5 counter cleared high", 64'(d), 64'h0);
        idle(40);
        wr(3'd6, 32'h0002_0000);
        rd(3'd6, d); chk("R5 request lowered", 64'(d), 64'h0);
        rd(3'd0, d); chk_range("R5 second write keeps counting", 64'(d), 64'd40, 64'd200);
    endtask

    // R10: ATIM window end follows next beacon and is never zero-length
    task automatic t_atim_rule();
        logic [31:0] d;
        wr(3'd6, 32'h0);
        wr(3'd2, 32'd200);
        rd(3'd5, d); chk("R10 atim follows nbt", 64'(d), 64'd201);
        wr(3'd5, 32'd300);
        rd(3'd5, d); chk("R10 atim direct write", 64'(d), 64'd300);
        wr(3'd5, 32'd200);
        rd(3'd5, d); chk("R10 zero window refused", 64'(d), 64'd201);
    endtask

    // R8: nothing fires or advances with enable clear
    task automatic t_disabled();
        logic [31:0] d;
        wr(3'd6, 32'h0);
        ext_load(64'd0);
        wr(3'd2, 32'd2);
        snap();
        idle(64);
        chk("R8 no nbt event", 64'(n_evt[0] - base[0]), 64'd0);
        chk("R8 no atim event", 64'(n_evt[3] - base[3]), 64'd0);
        rd(3'd2, d); chk("R8 nbt unchanged", 64'(d), 64'd2);
        rd(3'd5, d); chk("R8 atim unchanged", 64'(d), 64'd3);
    endtask

    // R6, R7: periodic firing over three intervals of 5 TU
    task automatic t_firing();
        logic [31:0] d;
        wr(3'd6, 32'd5);
        wr(3'd3, 32'd16);
        wr(3'd4, 32'd8);
        wr(3'd2, 32'd3);
        ext_load(64'd0);
        wr(3'd6, 32'h0001_0005);
        snap();
        idle(226);
        wr(3'd6, 32'd5);
        chk("R6 nbt pulses", 64'(n_evt[0] - base[0]), 64'd3);
        chk("R6 atim pulses", 64'(n_evt[3] - base[3]), 64'd3);
        chk("R7 dma pulses", 64'(n_evt[1] - base[1]), 64'd3);
        chk("R7 swba pulses", 64'(n_evt[2] - base[2]), 64'd3);
        rd(3'd2, d); chk("R6 nbt advanced", 64'(d), 64'd18);
        rd(3'd5, d); chk("R6 atim advanced", 64'(d), 64'd19);
        rd(3'd3, d); chk("R7 dma advanced in eighths", 64'(d), 64'd136);
        rd(3'd4, d); chk("R7 swba advanced in eighths", 64'(d), 64'd128);
    endtask

    // R9: a jump past the timer strands it until the TU count wraps
    task automatic t_strand();
        logic [31:0] d;
        wr(3'd6, 32'd10);
        wr(3'd3, 32'h7000);
        wr(3'd4, 32'h7000);
        wr(3'd2, 32'd100);
        ext_load(64'(105 << TU_SH));
        wr(3'd6, 32'h0001_000A);
        snap();
        idle(48);
        chk("R9 stranded nbt silent", 64'(n_evt[0] - base[0]), 64'd0);
        chk("R9 stranded atim silent", 64'(n_evt[3] - base[3]), 64'd0);
        rd(3'd2, d); chk("R9 stranded nbt value", 64'(d), 64'd100);
        ext_load(64'((65636 << TU_SH) - 8));
        snap();
        idle(20);
        chk("R9 fires after wrap", 64'(n_evt[0] - base[0]), 64'd1);
        rd(3'd2, d); chk("R9 advanced after wrap", 64'(d), 64'd110);
        wr(3'd6, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_counter();
        t_rst_req();
        t_atim_rule();
        t_disabled();
        t_firing();
        t_strand();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL all watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule